// File: doc/BRIEF.md
# Per-Master Access Permission Guard

This block sits after the page walker of an address translation unit. For each access it takes the translated page entry and reads a 4-bit authority index from it. That index selects one of sixteen authority domains. The block then looks up whether the requesting master may read or write in that domain, and answers allow or deny in the same cycle.

Denied accesses are logged for each master: the faulting virtual address and the page entry are stored, and a status bit is raised. The walker also reports invalid first-level and second-level entries through strobes. Those faults are logged in their own address and blame registers. A register port gives software read and write access to the domain table, the interrupt enable and the write-one-to-clear status. A level interrupt is raised while any enabled status bit is set.

Top module: `mmu_perm_guard`

## Requirements
- R1: The authority index is page-entry bits 7:4. Domains d and d+1 (d even) share the register at byte offset 0x0B0 + (d/2)*4. The even domain of the pair uses bits 15:0 and the odd domain uses bits 31:16.
- R2: Within a domain's 16-bit half, bit m*2 set denies reads by master m and bit m*2+1 set denies writes by master m. `acc_ok` is 1 exactly when the selected bit is clear.
- R3: After reset, domain register 0x0B0 reads 0x00000AAA, so domain 0 allows reads and denies writes for all six masters. The other domain registers read 0. Status (0x108) reads 0, enable (0x100) reads 0, and `irq` is low.
- R4: A valid denied access by master m sets status bit m on the next clock. On the same clock it stores the virtual address at 0x110+m*4 and the page entry at 0x150+m*4.
- R5: A valid allowed access leaves the status register and the error registers unchanged.
- R6: A first-level fault strobe sets status bit 16, stores the walk address at 0x130 and stores the one-hot master at 0x180. A second-level strobe does the same with bit 17, 0x134 and 0x184.
- R7: Writing a value to 0x104 clears exactly the status bits that are 1 in that value. Other status bits are untouched. Register 0x104 reads 0.
- R8: When a fault and a clear of the same status bit land in one cycle, the bit ends up set.
- R9: `irq` is the OR over all bits of status AND enable. The enable register at 0x100 is readable and writable.
- R10: Writes to the status register 0x108 have no effect on its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access presented for checking |
| acc_master | input | 3 | Requesting master id (0 to 5) |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_vaddr | input | 32 | Virtual address of the access |
| acc_pte | input | 32 | Translated page entry |
| acc_ok | output | 1 | Access allowed |
| walk_l1_fault | input | 1 | Invalid first-level entry strobe |
| walk_l2_fault | input | 1 | Invalid second-level entry strobe |
| walk_master | input | 3 | Master whose walk faulted |
| walk_vaddr | input | 32 | Address of the faulted walk |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Level interrupt |

## Verification
A corrupted domain word appears at once on `acc_ok`, in the same cycle the matching index and master are presented. It also reads back directly from its register offset. A wrong status or error-log register is visible one clock after the access that should have written it, both on the readback port and, when the bit is enabled, on `irq`. The bench therefore probes each half of a domain pair and both directions. It reads the logs right after each event and forces a fault to coincide with a clear.

// File: rtl/mmu_perm_guard.sv
module mmu_perm_guard #(
  parameter int NUM_MASTERS = 6,
  parameter int NUM_DOMAINS = 16,
  parameter int AW          = 32,
  parameter int RAW         = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           acc_valid,
  input  logic [2:0]     acc_master,
  input  logic           acc_write,
  input  logic [AW-1:0]  acc_vaddr,
  input  logic [31:0]    acc_pte,
  output logic           acc_ok,
  input  logic           walk_l1_fault,
  input  logic           walk_l2_fault,
  input  logic [2:0]     walk_master,
  input  logic [AW-1:0]  walk_vaddr,
  input  logic           reg_wr,
  input  logic [RAW-1:0] reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           irq
);
  localparam int NPAIR = NUM_DOMAINS / 2;
  localparam logic [RAW-1:0] A_DOM  = RAW'(9'h0B0);
  localparam logic [RAW-1:0] A_EN   = RAW'(9'h100);
  localparam logic [RAW-1:0] A_CLR  = RAW'(9'h104);
  localparam logic [RAW-1:0] A_ST   = RAW'(9'h108);
  localparam logic [RAW-1:0] A_EA   = RAW'(9'h110);
  localparam logic [RAW-1:0] A_L1A  = RAW'(9'h130);
  localparam logic [RAW-1:0] A_L2A  = RAW'(9'h134);
  localparam logic [RAW-1:0] A_ED   = RAW'(9'h150);
  localparam logic [RAW-1:0] A_L1W  = RAW'(9'h180);
  localparam logic [RAW-1:0] A_L2W  = RAW'(9'h184);
  localparam logic [31:0] ST_MASK   = 32'h0003_0000 | ((32'h1 << NUM_MASTERS) - 32'h1);
  localparam logic [31:0] DOM0_INIT = {16'h0, 16'hAAAA & 16'((32'h1 << (2*NUM_MASTERS)) - 32'h1)};

  logic [31:0]   dom_q [NPAIR];
  logic [31:0]   st_q, en_q, l1w_q, l2w_q;
  logic [AW-1:0] ea_q [NUM_MASTERS];
  logic [31:0]   ed_q [NUM_MASTERS];
  logic [AW-1:0] l1a_q, l2a_q;

  logic [3:0]  aci;
  logic [31:0] dom_word;
  logic        deny, m_ok;
  logic [31:0] set_v, clr_v, st_d;

  assign aci      = acc_pte[7:4];
  assign dom_word = dom_q[aci[3:1]];
  assign deny     = dom_word[{aci[0], acc_master, acc_write}];
  assign acc_ok   = !deny;
  assign m_ok     = 32'(acc_master) < NUM_MASTERS;
  assign irq      = |(st_q & en_q);

  always_comb begin
    set_v = '0;
    if (acc_valid && deny && m_ok) set_v[acc_master] = 1'b1;
    if (walk_l1_fault) set_v[16] = 1'b1;
    if (walk_l2_fault) set_v[17] = 1'b1;
    clr_v = (reg_wr && reg_addr == A_CLR) ? reg_wdata : '0;
    st_d  = ((st_q & ~clr_v) | set_v) & ST_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPAIR; i++) dom_q[i] <= (i == 0) ? DOM0_INIT : '0;
      for (int m = 0; m < NUM_MASTERS; m++) begin
        ea_q[m] <= '0;
        ed_q[m] <= '0;
      end
      st_q <= '0; en_q <= '0; l1w_q <= '0; l2w_q <= '0;
      l1a_q <= '0; l2a_q <= '0;
    end else begin
      st_q <= st_d;
      if (reg_wr) begin
        for (int i = 0; i < NPAIR; i++)
          if (reg_addr == A_DOM + RAW'(4*i)) dom_q[i] <= reg_wdata;
        if (reg_addr == A_EN) en_q <= reg_wdata & ST_MASK;
      end
      if (acc_valid && deny && m_ok) begin
        ea_q[acc_master] <= acc_vaddr;
        ed_q[acc_master] <= acc_pte;
      end
      if (walk_l1_fault) begin
        l1a_q <= walk_vaddr;
        l1w_q <= 32'h1 << walk_master;
      end
      if (walk_l2_fault) begin
        l2a_q <= walk_vaddr;
        l2w_q <= 32'h1 << walk_master;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NPAIR; i++)
      if (reg_addr == A_DOM + RAW'(4*i)) reg_rdata = dom_q[i];
    for (int m = 0; m < NUM_MASTERS; m++) begin
      if (reg_addr == A_EA + RAW'(4*m)) reg_rdata = 32'(ea_q[m]);
      if (reg_addr == A_ED + RAW'(4*m)) reg_rdata = ed_q[m];
    end
    case (reg_addr)
      A_EN:    reg_rdata = en_q;
      A_ST:    reg_rdata = st_q;
      A_L1A:   reg_rdata = 32'(l1a_q);
      A_L2A:   reg_rdata = 32'(l2a_q);
      A_L1W:   reg_rdata = l1w_q;
      A_L2W:   reg_rdata = l2w_q;
      default: ;
    endcase
  end

  AST_DENY_LOGS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_ok && m_ok) |=> st_q[$past(acc_master)]); // R4

  AST_ALLOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ok && !walk_l1_fault && !walk_l2_fault && !(reg_wr && reg_addr == A_CLR))
      |=> $stable(st_q)); // R5

  AST_L1_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    walk_l1_fault |=> (l1a_q == $past(walk_vaddr)) && st_q[16]); // R6

  AST_FAULT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_l2_fault && reg_wr && reg_addr == A_CLR && reg_wdata[17]) |=> st_q[17]); // R8

  AST_CLEAR_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_CLR && reg_wdata[16] && !walk_l1_fault) |=> !st_q[16]); // R7

  AST_STATUS_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_ST && !acc_valid && !walk_l1_fault && !walk_l2_fault) |=> $stable(st_q)); // R10
endmodule

// File: tb/mmu_perm_guard_test.sv
module mmu_perm_guard_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        acc_valid = 0, acc_write = 0;
  logic [2:0]  acc_master = 0;
  logic [31:0] acc_vaddr = 0, acc_pte = 0;
  logic        acc_ok;
  logic        walk_l1_fault = 0, walk_l2_fault = 0;
  logic [2:0]  walk_master = 0;
  logic [31:0] walk_vaddr = 0;
  logic        reg_wr = 0;
  logic [8:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        irq;

  always #5 clk = ~clk;

  mmu_perm_guard uut (.*);

  typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
  item_t sb_q[$];
  logic  chk_req = 0;
  int    checks = 0, failures = 0;
  bit    done = 0;

  always @(negedge clk) begin
    if (chk_req && sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = sb_q.pop_front();
      act = (it.kind == 0) ? reg_rdata : (it.kind == 1) ? {31'b0, acc_ok} : {31'b0, irq};
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_item(int kind, logic [31:0] exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    chk_req = 1;
    @(negedge clk); #1;
    chk_req = 0;
  endtask

  task automatic rd(logic [8:0] a, logic [31:0] exp, string tag);
    @(posedge clk); #1;
    reg_addr = a;
    expect_item(0, exp, tag);
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic probe(logic [2:0] m, logic w, logic [3:0] aci, logic exp, string tag);
    @(posedge clk); #1;
    acc_valid = 0; acc_master = m; acc_write = w; acc_pte = {24'h0, aci, 4'h2};
    expect_item(1, {31'b0, exp}, tag);
  endtask

  task automatic access(logic [2:0] m, logic w, logic [31:0] va, logic [31:0] pte);
    @(posedge clk); #1;
    acc_valid = 1; acc_master = m; acc_write = w; acc_vaddr = va; acc_pte = pte;
    @(posedge clk); #1;
    acc_valid = 0;
  endtask

  task automatic chk_irq(logic exp, string tag);
    @(posedge clk); #1;
    expect_item(2, {31'b0, exp}, tag);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    rd(9'h0B0, 32'h0000_0AAA, "R3 domain0 reset");
    rd(9'h0B4, 32'h0, "R3 domain2/3 reset");
    rd(9'h108, 32'h0, "R3 status reset");
    rd(9'h100, 32'h0, "R3 enable reset");
    chk_irq(0, "R3 irq reset");

    probe(3'd2, 0, 4'd0, 1, "R2 domain0 read allowed");
    probe(3'd2, 1, 4'd0, 0, "R2 domain0 write denied");

    wr(9'h0B4, 32'h0100_0000);
    rd(9'h0B4, 32'h0100_0000, "R1 domain reg readback");
    probe(3'd4, 0, 4'd3, 0, "R1 odd domain upper half read denied");
    probe(3'd4, 1, 4'd3, 1, "R2 odd domain write allowed");
    probe(3'd4, 0, 4'd2, 1, "R1 even domain lower half unaffected");
    probe(3'd3, 0, 4'd3, 1, "R2 other master unaffected");

    access(3'd4, 0, 32'h1234_5678, 32'hABCD_E031);
    rd(9'h108, 32'h0000_0010, "R4 status bit master4");
    rd(9'h120, 32'h1234_5678, "R4 error address master4");
    rd(9'h160, 32'hABCD_E031, "R4 error data master4");
    chk_irq(0, "R9 irq masked");

    wr(9'h100, 32'h0000_0010);
    rd(9'h100, 32'h0000_0010, "R9 enable readback");
    chk_irq(1, "R9 irq enabled");

    wr(9'h108, 32'h0);
    rd(9'h108, 32'h0000_0010, "R10 status write ignored");

    wr(9'h104, 32'h0000_0001);
    rd(9'h108, 32'h0000_0010, "R7 clear of unset bit");
    rd(9'h104, 32'h0, "R7 clear reads zero");
    wr(9'h104, 32'h0000_0010);
    rd(9'h108, 32'h0, "R7 clear set bit");
    chk_irq(0, "R9 irq drops after clear");

    access(3'd1, 0, 32'h5555_0000, 32'h0000_0002);
    rd(9'h108, 32'h0, "R5 allowed access status");
    rd(9'h114, 32'h0, "R5 allowed access error address");

    @(posedge clk); #1;
    walk_l1_fault = 1; walk_master = 3'd3; walk_vaddr = 32'hDEAD_0000;
    @(posedge clk); #1;
    walk_l1_fault = 0;
    rd(9'h108, 32'h0001_0000, "R6 level1 status");
    rd(9'h130, 32'hDEAD_0000, "R6 level1 address");
    rd(9'h180, 32'h0000_0008, "R6 level1 master");

    @(posedge clk); #1;
    walk_l2_fault = 1; walk_master = 3'd5; walk_vaddr = 32'h0BAD_1000;
    @(posedge clk); #1;
    walk_l2_fault = 0;
    rd(9'h108, 32'h0003_0000, "R6 level2 status");
    rd(9'h134, 32'h0BAD_1000, "R6 level2 address");
    rd(9'h184, 32'h0000_0020, "R6 level2 master");

    @(posedge clk); #1;
    walk_l2_fault = 1; walk_master = 3'd0; walk_vaddr = 32'h0000_3000;
    reg_wr = 1; reg_addr = 9'h104; reg_wdata = 32'h0003_0000;
    @(posedge clk); #1;
    walk_l2_fault = 0; reg_wr = 0;
    rd(9'h108, 32'h0002_0000, "R8 fault wins over clear");
    rd(9'h184, 32'h0000_0001, "R8 level2 master updated");

    repeat (2) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule